// File: doc/BRIEF.md
# Converter Register Initialization Sequencer

This block sits on the host side of an eight-channel data converter and brings it into its operating configuration after power-up. When it sees a start pulse, it first pulls the converter's active-low reset line low for a fixed time and releases it. After a settling interval it sends a fixed, ordered list of register writes over a three-wire serial link: an active-low select, a serial clock and serial data.

Each write is one 24-bit frame. It carries an 8-bit register address and then a 16-bit data word, most significant bit first. Four writes always go out. A fifth write is added when the `ac_coupled_i` strap, captured at the start pulse, says the converter's analog inputs are AC-coupled. When the last frame ends, `done_o` rises and stays high until the next accepted start.

The serial clock is the system clock divided by `CLK_DIV`. Serial data changes only on a falling edge of the serial clock, so it is stable at every rising edge.

Top module: `conv_init_seq`

## Requirements
- R1: During and after synchronous reset, `sel_n_o` = 1, `sclk_o` = 0, `conv_rst_n_o` = 1 and `done_o` = 0.
- R2: A start pulse accepted while idle drives `conv_rst_n_o` low for exactly RST_LOW_CYC (default 16) system clocks, then releases it.
- R3: `sel_n_o` first falls exactly RST_SETTLE_CYC (default 16) system clocks after `conv_rst_n_o` rises. Select never goes low while the converter reset is low.
- R4: Each frame is 24 bits, sampled on rising edges of `sclk_o` while `sel_n_o` is low. Bits 23..16 carry the address and bits 15..0 carry the data, most significant bit first. `sdata_o` holds steady while `sclk_o` is high.
- R5: While select is high, `sclk_o` stays low. Within a frame, `sdata_o` changes only in the same cycle that `sclk_o` falls.
- R6: `sclk_o` has a period of CLK_DIV system clocks. `sel_n_o` stays low for exactly 24 serial clock periods (24*CLK_DIV system clocks) per frame and carries exactly 24 rising edges.
- R7: Between consecutive frames, `sel_n_o` stays high for exactly GAP_SCLK*CLK_DIV system clocks (default 2*8 = 16).
- R8: The first four frames are (address, data) = (0x03, 0x0002), (0x01, 0x0010), (0xC7, 0x8001), (0xDE, 0x01C0), in that order.
- R9: When `ac_coupled_i` is 1 at the accepted start, a fifth frame (0xE2, 0x00C0) follows. When it is 0, no fifth frame is sent. Later changes to the strap have no effect on a run already in progress.
- R10: `done_o` rises in the same cycle that the last frame's select rises. It stays high while idle and falls on the clock after the next accepted start. It is 0 throughout a run.
- R11: A start pulse that arrives while a run is in progress is ignored. No new reset pulse is issued and no extra frame is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to run the sequence |
| ac_coupled_i | input | 1 | Strap: analog inputs are AC-coupled |
| conv_rst_n_o | output | 1 | Active-low reset to the converter |
| sel_n_o | output | 1 | Active-low serial select |
| sclk_o | output | 1 | Serial clock |
| sdata_o | output | 1 | Serial data |
| done_o | output | 1 | Sequence complete |

## Verification
Some rules can be checked on every cycle, and the assertions cover those:
- the serial clock stays idle while select is high;
- data stays stable while the serial clock is high, and changes only on its falling edge;
- select stays off while the converter is held in reset;
- done stays low whenever a run is active;
- a start pulse cannot re-enter the reset phase during a run.

Other behaviour can only be shown by the bench's scenarios, which compare captured frames against an expected queue:
- exact durations of the reset pulse, the settling time, the select window and the inter-frame gap;
- frame contents and their order;
- whether the optional fifth frame is present;
- the timing of done.

// File: rtl/conv_init_pkg.sv
package conv_init_pkg;
  localparam int ADDR_W    = 8;
  localparam int DATA_W    = 16;
  localparam int FRAME_W   = ADDR_W + DATA_W;
  localparam int NUM_WORDS = 5;
  localparam int IDX_W     = $clog2(NUM_WORDS);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RST_LO,
    ST_RST_SETTLE,
    ST_SHIFT,
    ST_GAP
  } seq_state_t;
endpackage

// File: rtl/conv_init_rom.sv
module conv_init_rom
  import conv_init_pkg::*;
(
  input  logic [IDX_W-1:0]   idx_i,
  output logic [FRAME_W-1:0] word_o
);
  // Entry order is behaviour: the converter requires this sequence.
  always_comb begin
    case (idx_i)
      IDX_W'(0): word_o = {8'h03, 16'h0002};
      IDX_W'(1): word_o = {8'h01, 16'h0010};
      IDX_W'(2): word_o = {8'hC7, 16'h8001};
      IDX_W'(3): word_o = {8'hDE, 16'h01C0};
      IDX_W'(4): word_o = {8'hE2, 16'h00C0};
      default:   word_o = '0;
    endcase
  end
endmodule

// File: rtl/conv_init_serdes.sv
module conv_init_serdes #(
  parameter int CLK_DIV = 8,
  parameter int FRAME_W = 24
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] word_i,
  output logic               fin_o,
  output logic               sel_n_o,
  output logic               sclk_o,
  output logic               sdata_o
);
  localparam int HALF = CLK_DIV / 2;
  localparam int PH_W = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam int BC_W = $clog2(FRAME_W);

  logic               active;
  logic [PH_W-1:0]    ph;
  logic [BC_W-1:0]    bcnt;
  logic [FRAME_W-1:0] sh;
  logic               ph_end, bit_last;

  assign ph_end   = (ph == PH_W'(CLK_DIV - 1));
  assign bit_last = (bcnt == BC_W'(FRAME_W - 1));
  assign fin_o    = active && ph_end && bit_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      ph      <= '0;
      bcnt    <= '0;
      sh      <= '0;
      sel_n_o <= 1'b1;
      sclk_o  <= 1'b0;
      sdata_o <= 1'b0;
    end else if (load_i) begin
      active  <= 1'b1;
      ph      <= '0;
      bcnt    <= '0;
      sh      <= word_i;
      sel_n_o <= 1'b0;
      sclk_o  <= 1'b0;
      sdata_o <= word_i[FRAME_W-1];
    end else if (active) begin
      if (ph_end) begin
        ph     <= '0;
        sclk_o <= 1'b0;
        if (bit_last) begin
          active  <= 1'b0;
          sel_n_o <= 1'b1;
          sdata_o <= 1'b0;
        end else begin
          bcnt    <= bcnt + 1'b1;
          sh      <= sh << 1;
          sdata_o <= sh[FRAME_W-2];
        end
      end else begin
        ph     <= ph + 1'b1;
        sclk_o <= (ph >= PH_W'(HALF - 1));
      end
    end
  end

  assert_sclk_idle_R5: assert property (@(posedge clk) disable iff (rst)
    sel_n_o |-> !sclk_o);

  assert_data_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (sclk_o && $past(sclk_o)) |-> $stable(sdata_o));

  assert_data_on_fall_R5: assert property (@(posedge clk) disable iff (rst)
    (!sel_n_o && $past(!sel_n_o) && !$stable(sdata_o)) |-> $fell(sclk_o));
endmodule

// File: rtl/conv_init_seq.sv
module conv_init_seq
  import conv_init_pkg::*;
#(
  parameter int CLK_DIV        = 8,
  parameter int RST_LOW_CYC    = 16,
  parameter int RST_SETTLE_CYC = 16,
  parameter int GAP_SCLK       = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic ac_coupled_i,
  output logic conv_rst_n_o,
  output logic sel_n_o,
  output logic sclk_o,
  output logic sdata_o,
  output logic done_o
);
  localparam int GAP_CYC = GAP_SCLK * CLK_DIV;
  localparam int TOP_A   = (RST_LOW_CYC > RST_SETTLE_CYC) ? RST_LOW_CYC : RST_SETTLE_CYC;
  localparam int CNT_TOP = (TOP_A > GAP_CYC) ? TOP_A : GAP_CYC;
  localparam int CNT_W   = $clog2(CNT_TOP + 1);

  seq_state_t         state;
  logic [CNT_W-1:0]   cnt;
  logic [IDX_W-1:0]   idx;
  logic               ac_q;
  logic               load;
  logic               fin;
  logic [IDX_W-1:0]   last_idx;
  logic [FRAME_W-1:0] word;

  assign last_idx = ac_q ? IDX_W'(NUM_WORDS - 1) : IDX_W'(NUM_WORDS - 2);
  assign load = (state == ST_RST_SETTLE && cnt == CNT_W'(RST_SETTLE_CYC - 1)) ||
                (state == ST_GAP        && cnt == CNT_W'(GAP_CYC - 1));

  conv_init_rom u_rom (
    .idx_i  (idx),
    .word_o (word)
  );

  conv_init_serdes #(
    .CLK_DIV (CLK_DIV),
    .FRAME_W (FRAME_W)
  ) u_serdes (
    .clk     (clk),
    .rst     (rst),
    .load_i  (load),
    .word_i  (word),
    .fin_o   (fin),
    .sel_n_o (sel_n_o),
    .sclk_o  (sclk_o),
    .sdata_o (sdata_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      cnt          <= '0;
      idx          <= '0;
      ac_q         <= 1'b0;
      done_o       <= 1'b0;
      conv_rst_n_o <= 1'b1;
    end else begin
      case (state)
        ST_IDLE: if (start_i) begin
          state        <= ST_RST_LO;
          cnt          <= '0;
          idx          <= '0;
          ac_q         <= ac_coupled_i;
          done_o       <= 1'b0;
          conv_rst_n_o <= 1'b0;
        end
        ST_RST_LO: if (cnt == CNT_W'(RST_LOW_CYC - 1)) begin
          conv_rst_n_o <= 1'b1;
          cnt          <= '0;
          state        <= ST_RST_SETTLE;
        end else cnt <= cnt + 1'b1;
        ST_RST_SETTLE: if (load) begin
          cnt   <= '0;
          state <= ST_SHIFT;
        end else cnt <= cnt + 1'b1;
        ST_SHIFT: if (fin) begin
          cnt <= '0;
          if (idx == last_idx) begin
            done_o <= 1'b1;
            state  <= ST_IDLE;
          end else begin
            idx   <= idx + 1'b1;
            state <= ST_GAP;
          end
        end
        ST_GAP: if (load) begin
          cnt   <= '0;
          state <= ST_SHIFT;
        end else cnt <= cnt + 1'b1;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_sel_after_reset_R3: assert property (@(posedge clk) disable iff (rst)
    !conv_rst_n_o |-> sel_n_o);

  assert_done_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (sel_n_o && conv_rst_n_o));

  assert_done_low_busy_R10: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |-> !done_o);

  assert_busy_start_R11: assert property (@(posedge clk) disable iff (rst)
    (start_i && state != ST_IDLE && state != ST_RST_LO) |=> (state != ST_RST_LO));

  assert_idx_bound_R9: assert property (@(posedge clk) disable iff (rst)
    idx <= last_idx);
endmodule

// File: tb/conv_init_seq_test.sv
`timescale 1ns/1ps
module conv_init_seq_test;
  logic clk = 1'b0;
  logic rst, start_i, ac_coupled_i;
  logic conv_rst_n_o, sel_n_o, sclk_o, sdata_o, done_o;

  always #4 clk = ~clk;

  conv_init_seq uut (
    .clk          (clk),
    .rst          (rst),
    .start_i      (start_i),
    .ac_coupled_i (ac_coupled_i),
    .conv_rst_n_o (conv_rst_n_o),
    .sel_n_o      (sel_n_o),
    .sclk_o       (sclk_o),
    .sdata_o      (sdata_o),
    .done_o       (done_o)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;
  logic [23:0] expq[$];
  int frames = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // Monitor: measures timing and collects frames, compares with scoreboard
  logic p_rst_n = 1'b1, p_sel_n = 1'b1, p_sclk = 1'b0;
  int rst_lo_cnt = 0, settle_cnt = 0, sel_lo_cnt = 0, gap_cnt = 0, nbits = 0;
  bit in_settle = 0, in_gap = 0;
  logic [23:0] shreg = '0;

  always @(negedge clk) begin
    if (rst) begin
      p_rst_n = 1'b1; p_sel_n = 1'b1; p_sclk = 1'b0;
      rst_lo_cnt = 0; in_settle = 0; in_gap = 0;
    end else begin
      if (!conv_rst_n_o) rst_lo_cnt++;
      if (conv_rst_n_o && !p_rst_n) begin
        check(rst_lo_cnt == 16, "R2 reset low length", rst_lo_cnt, 16);
        rst_lo_cnt = 0; settle_cnt = 1; in_settle = 1; in_gap = 0;
      end else if (in_settle && sel_n_o) settle_cnt++;
      if (in_gap && sel_n_o && p_sel_n) gap_cnt++;
      if (!sel_n_o && p_sel_n) begin
        if (in_settle) check(settle_cnt == 16, "R3 settle length", settle_cnt, 16);
        else if (in_gap) check(gap_cnt == 16, "R7 gap length", gap_cnt, 16);
        check(done_o == 1'b0, "R10 done low in run", done_o, 0);
        in_settle = 0; in_gap = 0;
        sel_lo_cnt = 1; nbits = 0; shreg = '0;
      end else if (!sel_n_o) sel_lo_cnt++;
      if (!sel_n_o && sclk_o && !p_sclk) begin
        shreg = {shreg[22:0], sdata_o};
        nbits++;
      end
      if (sel_n_o && !p_sel_n) begin
        check(sel_lo_cnt == 192, "R6 select window", sel_lo_cnt, 192);
        check(nbits == 24, "R6 rising edges per frame", nbits, 24);
        if (expq.size() == 0) check(0, "R9 unexpected frame", shreg, 0);
        else begin
          logic [23:0] e;
          e = expq.pop_front();
          check(shreg == e, "R4 R8 R9 frame content", shreg, e);
        end
        frames++;
        check(done_o == (expq.size() == 0), "R10 done at last frame", done_o, expq.size() == 0);
        in_gap = 1; gap_cnt = 1;
      end
      p_rst_n = conv_rst_n_o; p_sel_n = sel_n_o; p_sclk = sclk_o;
    end
  end

  // Driver
  task automatic push_base();
    expq.push_back({8'h03, 16'h0002});
    expq.push_back({8'h01, 16'h0010});
    expq.push_back({8'hC7, 16'h8001});
    expq.push_back({8'hDE, 16'h01C0});
  endtask

  task automatic pulse_start();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 4000 && !done_o; i++) @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    check(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int f0;
    rst = 1'b1; start_i = 1'b0; ac_coupled_i = 1'b0;
    repeat (4) @(negedge clk);
    // R1: reset state
    check(sel_n_o == 1'b1 && sclk_o == 1'b0, "R1 serial idle in reset", {sel_n_o, sclk_o}, 2'b10);
    check(conv_rst_n_o == 1'b1 && done_o == 1'b0, "R1 reset/done in reset", {conv_rst_n_o, done_o}, 2'b10);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(sel_n_o && !sclk_o && conv_rst_n_o && !done_o, "R1 after reset", {sel_n_o, sclk_o, conv_rst_n_o, done_o}, 4'b1010);

    // Run 1: DC-coupled, with a stray start mid-run (R11)
    f0 = frames;
    push_base();
    pulse_start();
    repeat (300) @(negedge clk);
    pulse_start();                     // R11: ignored while busy
    wait_done();
    repeat (400) @(negedge clk);
    check(frames - f0 == 4, "R8 R11 frame count dc", frames - f0, 4);
    check(expq.size() == 0, "R8 queue drained", expq.size(), 0);
    check(done_o == 1'b1, "R10 done held", done_o, 1);
    check(conv_rst_n_o == 1'b1, "R11 no extra reset", conv_rst_n_o, 1);

    // Run 2: AC-coupled, strap dropped after start (R9)
    f0 = frames;
    push_base();
    expq.push_back({8'hE2, 16'h00C0});
    ac_coupled_i = 1'b1;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0; ac_coupled_i = 1'b0;
    check(done_o == 1'b0, "R10 done falls after start", done_o, 0);
    wait_done();
    repeat (200) @(negedge clk);
    check(frames - f0 == 5, "R9 frame count ac", frames - f0, 5);

    // Run 3: DC again, no fifth frame
    f0 = frames;
    push_base();
    pulse_start();
    wait_done();
    repeat (200) @(negedge clk);
    check(frames - f0 == 4, "R9 no fifth frame", frames - f0, 4);
    check(done_o == 1'b1, "R10 done held end", done_o, 1);
    finish_run();
  end
endmodule